// File: doc/BRIEF.md
# Line Loop-Closure Detector

This block decides whether the terminal on a subscriber line has gone off-hook. It takes a stream of monitor-converter words (loop current or loop voltage) qualified by a valid strobe. It smooths them with a first-order low-pass filter and compares the smoothed level against one or two programmable thresholds. The comparator output must then stay changed for a programmable number of millisecond ticks before a status bit is allowed to follow it.

Detection runs only while the linefeed is in one of the two on-hook states that carry the line. In every other state the filter and comparator hold their values. A voltage mode reverses the sense of the comparison: a low loop voltage means the loop is closed. A hysteresis option makes the comparator use a band between a lower and an upper threshold instead of a single threshold. Each change of the debounced status can raise a sticky interrupt-pending bit, which software clears by writing a one.

Top module: `loop_closure_det`

## Requirements
- R1: Filter and comparator update only while `linefeed_state` is 3'b001 (on-hook active) or 3'b010 (on-hook transmission). In any other code both hold their value, so the status cannot change however the samples move.
- R2: On each valid sample in a qualifying state, the 16-bit filter state y becomes y + floor((x − y) · coef / 8192), where coef is the 13-bit `filt_coef`. The level that is compared is y[15:10].
- R3: Current mode (`volt_mode`=0) without hysteresis: the comparator reads closed exactly when the level is greater than `thr_upper`.
- R4: Voltage mode (`volt_mode`=1) without hysteresis: the comparator reads closed exactly when the level is less than `thr_upper`.
- R5: Current mode with `hyst_en`=1: the comparator becomes closed when the level is above `thr_upper`. It stays closed while the level is at or above `thr_lower`, and opens when the level drops below `thr_lower`.
- R6: Voltage mode with `hyst_en`=1: the comparator becomes closed when the level is below `thr_lower`. It stays closed while the level is at or below `thr_upper`, and opens when the level rises above `thr_upper`.
- R7: `loop_closed` takes the opposite state only on the tick that completes `deb_interval`+1 consecutive ticks with the comparator in that opposite state. In any cycle where the comparator agrees with `loop_closed`, the count returns to zero.
- R8: With `deb_interval` = 0, a disagreement is accepted on the first tick that sees it.
- R9: Every change of `loop_closed`, rising or falling, sets `irq_pending` on the same clock edge when `irq_enable` is 1. With `irq_enable` at 0, a change leaves `irq_pending` unchanged.
- R10: `irq_pending` is sticky. A cycle with `irq_clear`=1 clears it, unless a set event occurs in the same cycle, in which case the set wins.
- R11: Synchronous active-high `rst` clears the filter, the comparator, the debounce count, `loop_closed` and `irq_pending`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adc_sample | input | 16 | Loop current or voltage sample, unsigned |
| adc_valid | input | 1 | Sample strobe |
| linefeed_state | input | 3 | Present linefeed state code |
| filt_coef | input | 13 | Low-pass coefficient, fraction of 8192 |
| thr_upper | input | 6 | Upper threshold |
| thr_lower | input | 6 | Lower threshold (hysteresis only) |
| hyst_en | input | 1 | Use the hysteresis band |
| volt_mode | input | 1 | Compare loop voltage as a minimum |
| deb_interval | input | 7 | Debounce interval in ticks |
| tick_1ms | input | 1 | One-cycle debounce time base |
| irq_enable | input | 1 | Allow status changes to raise pending |
| irq_clear | input | 1 | Write-one-to-clear strobe for pending |
| loop_closed | output | 1 | Debounced loop-closure status |
| irq_pending | output | 1 | Sticky interrupt-pending flag |

## Verification
The bench builds the block with its default parameters: 16-bit samples, a 13-bit coefficient, 6-bit thresholds and a 7-bit interval, with linefeed codes 1 and 2 qualifying. At the full coefficient of 8191 the filter reaches any target level within a sample, so threshold crossings, band edges and count restarts can be placed on chosen cycles. A coefficient of 1024 then exercises the slow approach of the filter. Small intervals of 0 to 3 ticks keep every debounce window, restart and same-cycle set-and-clear reachable in a few hundred cycles.

// File: rtl/lcd_pkg.sv
package lcd_pkg;
    localparam int unsigned COEF_FRAC = 13;

    typedef enum logic [1:0] {
        CMP_CUR_PLAIN  = 2'b00,
        CMP_CUR_BAND   = 2'b01,
        CMP_VOLT_PLAIN = 2'b10,
        CMP_VOLT_BAND  = 2'b11
    } cmp_mode_e;

    function automatic cmp_mode_e pick_mode(input logic volt, input logic band);
        return cmp_mode_e'({volt, band});
    endfunction
endpackage

// File: rtl/lcd_iir.sv
module lcd_iir #(
    parameter int unsigned SAMPLE_W = 16,
    parameter int unsigned COEF_W   = 13,
    parameter int unsigned LVL_W    = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                gate_i,
    input  logic                vld_i,
    input  logic [SAMPLE_W-1:0] sample_i,
    input  logic [COEF_W-1:0]   coef_i,
    output logic [LVL_W-1:0]    level_o
);
    localparam int unsigned PW = SAMPLE_W + COEF_W + 2;

    typedef struct packed {
        logic [SAMPLE_W-1:0] acc;
    } iir_s;

    iir_s q, d;
    logic signed [SAMPLE_W:0] diff;
    logic signed [PW-1:0]     diff_x;
    logic signed [PW-1:0]     coef_x;
    logic signed [PW-1:0]     prod;
    logic signed [PW-1:0]     step;

    always_comb begin
        d      = q;
        diff   = $signed({1'b0, sample_i}) - $signed({1'b0, q.acc});
        diff_x = PW'(diff);
        coef_x = $signed(PW'(coef_i));
        prod   = diff_x * coef_x;
        step   = prod >>> COEF_W;
        if (gate_i && vld_i) begin
            d.acc = SAMPLE_W'(step + $signed({{(PW-SAMPLE_W){1'b0}}, q.acc}));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign level_o = q.acc[SAMPLE_W-1 -: LVL_W];

    assert_hold_when_idle_R1: assert property (@(posedge clk) disable iff (rst)
        !gate_i |=> $stable(q.acc));
    assert_no_sample_no_move_R2: assert property (@(posedge clk) disable iff (rst)
        !vld_i |=> $stable(q.acc));
endmodule

// File: rtl/lcd_thresh.sv
module lcd_thresh
    import lcd_pkg::*;
#(
    parameter int unsigned LVL_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             gate_i,
    input  logic [LVL_W-1:0] level_i,
    input  logic [LVL_W-1:0] upper_i,
    input  logic [LVL_W-1:0] lower_i,
    input  logic             band_i,
    input  logic             volt_i,
    output logic             closed_o
);
    typedef struct packed {
        logic closed;
    } cmp_s;

    cmp_s      q, d;
    cmp_mode_e mode;

    always_comb begin
        d    = q;
        mode = pick_mode(volt_i, band_i);
        if (gate_i) begin
            unique case (mode)
                CMP_CUR_PLAIN:  d.closed = level_i > upper_i;
                CMP_CUR_BAND:   d.closed = q.closed ? (level_i >= lower_i) : (level_i > upper_i);
                CMP_VOLT_PLAIN: d.closed = level_i < upper_i;
                CMP_VOLT_BAND:  d.closed = q.closed ? (level_i <= upper_i) : (level_i < lower_i);
                default:        d.closed = q.closed;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign closed_o = q.closed;

    assert_cmp_frozen_R1: assert property (@(posedge clk) disable iff (rst)
        !gate_i |=> $stable(closed_o));
    assert_current_above_R3: assert property (@(posedge clk) disable iff (rst)
        gate_i && !band_i && !volt_i && (level_i > upper_i) |=> closed_o);
    assert_voltage_below_R4: assert property (@(posedge clk) disable iff (rst)
        gate_i && !band_i && volt_i && (level_i < upper_i) |=> closed_o);
    assert_current_band_hold_R5: assert property (@(posedge clk) disable iff (rst)
        gate_i && band_i && !volt_i && closed_o && (level_i >= lower_i) |=> closed_o);
    assert_voltage_band_hold_R6: assert property (@(posedge clk) disable iff (rst)
        gate_i && band_i && volt_i && closed_o && (level_i <= upper_i) |=> closed_o);
endmodule

// File: rtl/lcd_debounce.sv
module lcd_debounce #(
    parameter int unsigned DEB_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             raw_i,
    input  logic [DEB_W-1:0] interval_i,
    output logic             state_o,
    output logic             flip_o
);
    typedef struct packed {
        logic             state;
        logic [DEB_W-1:0] cnt;
    } deb_s;

    deb_s q, d;

    always_comb begin
        d = q;
        if (raw_i == q.state) begin
            d.cnt = '0;
        end else if (tick_i) begin
            if (q.cnt >= interval_i) begin
                d.state = raw_i;
                d.cnt   = '0;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign state_o = q.state;
    assign flip_o  = d.state != q.state;

    assert_only_on_tick_R7: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(state_o));
    assert_restart_on_agree_R7: assert property (@(posedge clk) disable iff (rst)
        (raw_i == state_o) |=> (q.cnt == '0));
    assert_zero_interval_R8: assert property (@(posedge clk) disable iff (rst)
        tick_i && (interval_i == '0) && (raw_i != state_o) |=> (state_o == $past(raw_i)));
endmodule

// File: rtl/loop_closure_det.sv
module loop_closure_det #(
    parameter int unsigned SAMPLE_W  = 16,
    parameter int unsigned COEF_W    = 13,
    parameter int unsigned LVL_W     = 6,
    parameter int unsigned DEB_W     = 7,
    parameter int unsigned LF_W      = 3,
    parameter logic [LF_W-1:0] LF_ACTIVE = 3'd1,
    parameter logic [LF_W-1:0] LF_OHT    = 3'd2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [SAMPLE_W-1:0] adc_sample,
    input  logic                adc_valid,
    input  logic [LF_W-1:0]     linefeed_state,
    input  logic [COEF_W-1:0]   filt_coef,
    input  logic [LVL_W-1:0]    thr_upper,
    input  logic [LVL_W-1:0]    thr_lower,
    input  logic                hyst_en,
    input  logic                volt_mode,
    input  logic [DEB_W-1:0]    deb_interval,
    input  logic                tick_1ms,
    input  logic                irq_enable,
    input  logic                irq_clear,
    output logic                loop_closed,
    output logic                irq_pending
);
    typedef struct packed {
        logic pend;
    } irq_s;

    logic             gate;
    logic [LVL_W-1:0] level;
    logic             raw_closed;
    logic             flip;
    irq_s             q, d;

    assign gate = (linefeed_state == LF_ACTIVE) || (linefeed_state == LF_OHT);

    lcd_iir #(.SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W), .LVL_W(LVL_W)) u_iir (
        .clk(clk), .rst(rst), .gate_i(gate), .vld_i(adc_valid),
        .sample_i(adc_sample), .coef_i(filt_coef), .level_o(level)
    );

    lcd_thresh #(.LVL_W(LVL_W)) u_thresh (
        .clk(clk), .rst(rst), .gate_i(gate), .level_i(level),
        .upper_i(thr_upper), .lower_i(thr_lower), .band_i(hyst_en),
        .volt_i(volt_mode), .closed_o(raw_closed)
    );

    lcd_debounce #(.DEB_W(DEB_W)) u_deb (
        .clk(clk), .rst(rst), .tick_i(tick_1ms), .raw_i(raw_closed),
        .interval_i(deb_interval), .state_o(loop_closed), .flip_o(flip)
    );

    always_comb begin
        d = q;
        if (irq_clear)          d.pend = 1'b0;
        if (flip && irq_enable) d.pend = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign irq_pending = q.pend;

    assert_pend_needs_edge_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_pending) |-> (loop_closed != $past(loop_closed)));
    assert_set_beats_clear_R10: assert property (@(posedge clk) disable iff (rst)
        flip && irq_enable |=> irq_pending);
    assert_clear_works_R10: assert property (@(posedge clk) disable iff (rst)
        irq_clear && !(flip && irq_enable) |=> !irq_pending);
    assert_reset_clears_R11: assert property (@(posedge clk)
        rst |=> !loop_closed && !irq_pending);
endmodule

// File: tb/loop_closure_det_tb.sv
module loop_closure_det_tb;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] adc_sample = '0;
    logic        adc_valid = 1'b0;
    logic [2:0]  linefeed_state = '0;
    logic [12:0] filt_coef = 13'd8191;
    logic [5:0]  thr_upper = 6'd20;
    logic [5:0]  thr_lower = 6'd10;
    logic        hyst_en = 1'b0;
    logic        volt_mode = 1'b0;
    logic [6:0]  deb_interval = '0;
    logic        tick_1ms = 1'b0;
    logic        irq_enable = 1'b1;
    logic        irq_clear = 1'b0;
    logic        loop_closed;
    logic        irq_pending;

    always #(CLK_PERIOD/2) clk = ~clk;

    loop_closure_det u_dut (
        .clk(clk), .rst(rst), .adc_sample(adc_sample), .adc_valid(adc_valid),
        .linefeed_state(linefeed_state), .filt_coef(filt_coef),
        .thr_upper(thr_upper), .thr_lower(thr_lower), .hyst_en(hyst_en),
        .volt_mode(volt_mode), .deb_interval(deb_interval), .tick_1ms(tick_1ms),
        .irq_enable(irq_enable), .irq_clear(irq_clear),
        .loop_closed(loop_closed), .irq_pending(irq_pending)
    );

    typedef struct {
        logic  st;
        logic  pd;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   finished = 0;

    longint m_y = 0;
    logic   m_cmp = 0, m_st = 0, m_pd = 0;
    int     m_cnt = 0;

    // driver: drive one cycle, advance the model over the edge, queue expectation
    task automatic step(input int lvl, input bit vld, input bit tick, input bit clr,
                        input string tag);
        longint x, dlt;
        int     lv;
        logic   ncmp, nst, npd, gate;
        int     ncnt;
        x = longint'(lvl) * 1024 + 512;
        adc_sample = x[15:0];
        adc_valid  = vld;
        tick_1ms   = tick;
        irq_clear  = clr;
        @(posedge clk);
        if (rst) begin
            m_y = 0; m_cmp = 0; m_st = 0; m_cnt = 0; m_pd = 0;
        end else begin
            gate = (linefeed_state == 3'd1) || (linefeed_state == 3'd2);
            lv   = int'(m_y >> 10);
            ncmp = m_cmp;
            if (gate) begin
                if (!volt_mode && !hyst_en)     ncmp = lv > thr_upper;
                else if (!volt_mode)            ncmp = m_cmp ? (lv >= thr_lower) : (lv > thr_upper);
                else if (!hyst_en)              ncmp = lv < thr_upper;
                else                            ncmp = m_cmp ? (lv <= thr_upper) : (lv < thr_lower);
            end
            nst = m_st; ncnt = m_cnt;
            if (m_cmp == m_st) ncnt = 0;
            else if (tick) begin
                if (m_cnt >= deb_interval) begin nst = m_cmp; ncnt = 0; end
                else ncnt = m_cnt + 1;
            end
            npd = m_pd && !clr;
            if ((nst != m_st) && irq_enable) npd = 1;
            if (gate && vld) begin
                dlt = (x - m_y) * longint'(filt_coef);
                m_y = m_y + (dlt >>> 13);
            end
            m_cmp = ncmp; m_st = nst; m_cnt = ncnt; m_pd = npd;
        end
        exp_q.push_back('{st: m_st, pd: m_pd, tag: tag});
        #1;
    endtask

    task automatic run(input int n, input int lvl, input int tick_per, input string tag);
        for (int i = 0; i < n; i++)
            step(lvl, 1'b1, (tick_per > 0) && (i % tick_per == tick_per - 1), 1'b0, tag);
    endtask

    // monitor: compare queued expectations away from the active edge
    always @(negedge clk) begin
        while (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_checks++;
            if (loop_closed !== e.st || irq_pending !== e.pd) begin
                n_fail++;
                $display("FAIL %s: loop_closed=%0b irq_pending=%0b expected %0b %0b",
                         e.tag, loop_closed, irq_pending, e.st, e.pd);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #1;
        rst = 1;
        run(4, 40, 1, "R11 reset");
        rst = 0;
        // R1: non-qualifying state, high samples and ticks
        linefeed_state = 3'd0;
        run(20, 40, 1, "R1 gated off");
        linefeed_state = 3'd5;
        run(10, 40, 1, "R1 gated off");
        // R3/R8/R9: current mode, zero interval
        linefeed_state = 3'd2;
        run(12, 30, 3, "R3 R8 R9 close");
        // R10 sticky then clear
        run(5, 30, 0, "R10 sticky");
        step(30, 1, 0, 1, "R10 clear");
        run(3, 30, 0, "R10 cleared");
        // R7: interval 3, interrupted then sustained drop
        deb_interval = 7'd3;
        run(5, 5, 2, "R7 partial");
        run(4, 30, 2, "R7 restart");
        run(14, 5, 2, "R7 open");
        // R9 disabled
        irq_enable = 0;
        step(5, 1, 0, 1, "R9 clear");
        run(14, 30, 2, "R9 no pend");
        irq_enable = 1;
        // R4 voltage mode, other qualifying state
        linefeed_state = 3'd1;
        volt_mode = 1; deb_interval = 0;
        run(8, 40, 1, "R4 high volt");
        run(8, 15, 1, "R4 low volt");
        // R6 voltage band
        hyst_en = 1;
        run(8, 40, 1, "R6 open");
        run(8, 15, 1, "R6 mid stays");
        run(8, 5, 1, "R6 close");
        run(8, 15, 1, "R6 mid hold");
        run(8, 21, 1, "R6 reopen");
        // R5 current band
        volt_mode = 0;
        run(8, 25, 1, "R5 close");
        run(8, 15, 1, "R5 mid hold");
        run(8, 9, 1, "R5 open");
        run(8, 15, 1, "R5 mid stays");
        // R10 set wins over clear
        for (int i = 0; i < 8; i++) step(25, 1, 1, 1, "R10 set wins");
        // R2 slow filter
        hyst_en = 0;
        run(8, 5, 1, "R2 settle low");
        filt_coef = 13'd1024;
        run(60, 40, 1, "R2 slow rise");
        // R1 freeze mid-flight
        linefeed_state = 3'd4;
        run(20, 0, 1, "R1 frozen");
        // R11 reset mid-run
        rst = 1;
        run(3, 40, 1, "R11 reset");
        rst = 0;
        run(3, 0, 1, "R11 after");
        @(negedge clk);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule